// File: doc/BRIEF.md
# Seven-Instruction Single-Cycle RISC-V Core

This block is a small 32-bit processor that completes one instruction in every clock cycle. It handles seven RV32I instructions: add, sub, and, or, lw, sw and beq. In each cycle it fetches a word from its instruction store, which has an asynchronous read. It decodes the word, reads two source registers and runs the ALU. It then uses the data store if the instruction needs it and picks the next program counter. Results are written back at the clock edge that ends the cycle.

Both stores are arrays inside the core. A test environment preloads them before reset is released. The core has a clock, a synchronous active-high reset and two debug taps. One tap shows the current PC. The other is a combinational read port that can name any register.

Decode sorts every fetched word into one of five instruction classes: register, load, store, branch and inert. A main decoder maps the class to the control bits and the multiplexer selects. A second decoder combines the main decoder's arithmetic hint with funct3 and funct7 to pick the ALU operation. Each cycle ends in one of two PC transitions: sequential, to PC + 4, or branch-redirect, to the branch target.

Top module: `rvmini_core`

## Requirements
- R1: While reset is high at a rising edge, the PC becomes 0 and every register becomes 0. Reset is synchronous.
- R2: After any instruction other than a taken beq, the PC advances by exactly 4.
- R3: A beq has opcode 1100011. When its two source registers are equal, the next PC is the current PC plus the sign-extended offset {instr[31], instr[7], instr[30:25], instr[11:8], 0}. When they differ, R2 applies.
- R4: A word with opcode 0110011 writes rd with an ALU result. funct3 000 with funct7 0000000 selects add, and funct3 000 with funct7 0100000 selects sub. funct3 111 selects and, and funct3 110 selects or.
- R5: Register x0 always reads as 0 on every read port, and writes that target it are dropped.
- R6: lw (opcode 0000011) adds rs1 to the sign-extended instr[31:20] to form a byte address. It reads the data word at address bits [31:2] and writes that word to rd, not the sum.
- R7: sw (opcode 0100011) rebuilds its offset as {instr[31:25], instr[11:7]} and sign-extends it. It writes rs2 to the word at (rs1 + offset) bits [31:2] at the clock edge. It modifies no register, including the one named by bits [11:7].
- R8: A word whose opcode is not one of the four above writes no register and no memory word. The PC still advances by 4.
- R9: The debug read port returns, without a clock, the current value of the register that the select input names.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dbg_pc | output | XLEN | Address of the instruction now executing |
| dbg_rsel | input | $clog2(NREG) | Register index for the debug read port |
| dbg_rdata | output | XLEN | Combinational value of the selected register |

## Verification
The bench builds the core with its defaults: 32-bit data, 32 registers and 64-word instruction and data stores. With 64-word stores, the test program fits in the first twenty instruction words, and its data (constants, a stored sum and a word reached through a negative store offset) stays inside the first eight data words. The 5-bit debug select covers the whole register file. This lets every cycle be checked at the register named by bits [11:7] of the instruction just retired. A store or an inert word would corrupt that register if it wrote back by mistake.

// File: rtl/rvmini_pkg.sv
package rvmini_pkg;

    // Major opcodes handled by the core
    localparam logic [6:0] OPC_REG    = 7'b0110011;
    localparam logic [6:0] OPC_LOAD   = 7'b0000011;
    localparam logic [6:0] OPC_STORE  = 7'b0100011;
    localparam logic [6:0] OPC_BRANCH = 7'b1100011;

    // Instruction class chosen by the main decoder
    typedef enum logic [2:0] {
        CLS_INERT,
        CLS_REG,
        CLS_LOAD,
        CLS_STORE,
        CLS_BRANCH
    } insn_cls_e;

    // Hint passed from main decode to ALU decode
    typedef enum logic [1:0] {
        HINT_ADD,
        HINT_SUB,
        HINT_FUNCT
    } alu_hint_e;

    // Operation executed by the ALU
    typedef enum logic [1:0] {
        OP_ADD,
        OP_SUB,
        OP_AND,
        OP_OR
    } alu_op_e;

    // Immediate layout selector
    typedef enum logic [1:0] {
        IMM_I,
        IMM_S,
        IMM_B
    } imm_fmt_e;

    typedef struct packed {
        logic      reg_write;
        logic      mem_read;
        logic      mem_write;
        logic      branch;
        logic      b_from_imm;
        alu_hint_e hint;
        imm_fmt_e  imm_fmt;
    } ctrl_t;

endpackage

// File: rtl/rvmini_decode.sv
module rvmini_decode
    import rvmini_pkg::*;
(
    input  logic [6:0] opcode,
    input  logic [2:0] funct3,
    input  logic [6:0] funct7,
    output ctrl_t      ctrl,
    output alu_op_e    alu_op
);

    insn_cls_e cls;

    // Opcode classification
    always_comb begin
        unique case (opcode)
            OPC_REG:    cls = CLS_REG;
            OPC_LOAD:   cls = CLS_LOAD;
            OPC_STORE:  cls = CLS_STORE;
            OPC_BRANCH: cls = CLS_BRANCH;
            default:    cls = CLS_INERT;
        endcase
    end

    // Main control: one row per class
    always_comb begin
        ctrl = '{reg_write: 1'b0, mem_read: 1'b0, mem_write: 1'b0,
                 branch: 1'b0, b_from_imm: 1'b0, hint: HINT_ADD,
                 imm_fmt: IMM_I};
        unique case (cls)
            CLS_REG: begin
                ctrl.reg_write = 1'b1;
                ctrl.hint      = HINT_FUNCT;
            end
            CLS_LOAD: begin
                ctrl.reg_write  = 1'b1;
                ctrl.mem_read   = 1'b1;
                ctrl.b_from_imm = 1'b1;
                ctrl.imm_fmt    = IMM_I;
            end
            CLS_STORE: begin
                ctrl.mem_write  = 1'b1;
                ctrl.b_from_imm = 1'b1;
                ctrl.imm_fmt    = IMM_S;
            end
            CLS_BRANCH: begin
                ctrl.branch  = 1'b1;
                ctrl.hint    = HINT_SUB;
                ctrl.imm_fmt = IMM_B;
            end
            CLS_INERT: begin
                ctrl.hint = HINT_ADD;
            end
            default: begin
                ctrl.hint = HINT_ADD;
            end
        endcase
    end

    // ALU control: hint plus function fields
    always_comb begin
        alu_op = OP_ADD;
        unique case (ctrl.hint)
            HINT_ADD: alu_op = OP_ADD;
            HINT_SUB: alu_op = OP_SUB;
            HINT_FUNCT: begin
                unique case (funct3)
                    3'b000:  alu_op = (funct7 == 7'b0100000) ? OP_SUB : OP_ADD;
                    3'b111:  alu_op = OP_AND;
                    3'b110:  alu_op = OP_OR;
                    default: alu_op = OP_ADD;
                endcase
            end
            default: alu_op = OP_ADD;
        endcase
    end

endmodule

// File: rtl/rvmini_immgen.sv
module rvmini_immgen
    import rvmini_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [31:7]     ins_hi,
    input  imm_fmt_e        fmt,
    output logic [XLEN-1:0] imm
);

    localparam int EXT12 = XLEN - 12;
    localparam int EXT13 = XLEN - 13;

    logic [11:0] raw_i;
    logic [11:0] raw_s;
    logic [12:0] raw_b;

    assign raw_i = ins_hi[31:20];
    assign raw_s = {ins_hi[31:25], ins_hi[11:7]};
    assign raw_b = {ins_hi[31], ins_hi[7], ins_hi[30:25], ins_hi[11:8], 1'b0};

    always_comb begin
        unique case (fmt)
            IMM_I:   imm = {{EXT12{raw_i[11]}}, raw_i};
            IMM_S:   imm = {{EXT12{raw_s[11]}}, raw_s};
            IMM_B:   imm = {{EXT13{raw_b[12]}}, raw_b};
            default: imm = {{EXT12{raw_i[11]}}, raw_i};
        endcase
    end

endmodule

// File: rtl/rvmini_regfile.sv
module rvmini_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    localparam int RAW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [RAW-1:0]  ra1,
    input  logic [RAW-1:0]  ra2,
    input  logic [RAW-1:0]  ra3,
    output logic [XLEN-1:0] rd1,
    output logic [XLEN-1:0] rd2,
    output logic [XLEN-1:0] rd3,
    input  logic            we,
    input  logic [RAW-1:0]  wa,
    input  logic [XLEN-1:0] wd
);

    logic [XLEN-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                regs[i] <= '0;
            end
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    // Index 0 is hard-wired to zero on every port
    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
    assign rd3 = (ra3 == '0) ? '0 : regs[ra3];

endmodule

// File: rtl/rvmini_alu.sv
module rvmini_alu
    import rvmini_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y,
    output logic            zero
);

    always_comb begin
        unique case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/rvmini_core.sv
module rvmini_core
    import rvmini_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int NREG       = 32,
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64
) (
    input  logic                    clk,
    input  logic                    rst,
    output logic [XLEN-1:0]         dbg_pc,
    input  logic [$clog2(NREG)-1:0] dbg_rsel,
    output logic [XLEN-1:0]         dbg_rdata
);

    localparam int RAW = $clog2(NREG);
    localparam int IAW = $clog2(IMEM_WORDS);
    localparam int DAW = $clog2(DMEM_WORDS);
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    // Instruction store: asynchronous read, filled before reset release
    logic [31:0] imem [IMEM_WORDS];

    initial begin
        for (int i = 0; i < IMEM_WORDS; i++) begin
            imem[i] = 32'h0;
        end
    end

    // Data store: asynchronous read, written at the clock edge
    logic [XLEN-1:0] dmem [DMEM_WORDS];

    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] pc_d;
    logic [31:0]     instr;
    ctrl_t           ctrl;
    alu_op_e         alu_op;
    logic [XLEN-1:0] imm;
    logic [XLEN-1:0] rs1_val;
    logic [XLEN-1:0] rs2_val;
    logic [XLEN-1:0] alu_b;
    logic [XLEN-1:0] alu_y;
    logic            alu_zero;
    logic [XLEN-1:0] dm_rdata;
    logic [DAW-1:0]  dm_idx;
    logic            dm_we;
    logic            rf_we;
    logic [XLEN-1:0] wb_data;
    logic [XLEN-1:0] pc_seq;
    logic [XLEN-1:0] pc_tgt;
    logic            redirect;

    // Fetch
    assign instr = imem[pc_q[IAW+1:2]];

    rvmini_decode u_decode (
        .opcode (instr[6:0]),
        .funct3 (instr[14:12]),
        .funct7 (instr[31:25]),
        .ctrl   (ctrl),
        .alu_op (alu_op)
    );

    rvmini_immgen #(.XLEN(XLEN)) u_immgen (
        .ins_hi (instr[31:7]),
        .fmt    (ctrl.imm_fmt),
        .imm    (imm)
    );

    rvmini_regfile #(.XLEN(XLEN), .NREG(NREG)) u_regfile (
        .clk (clk),
        .rst (rst),
        .ra1 (instr[15 +: RAW]),
        .ra2 (instr[20 +: RAW]),
        .ra3 (dbg_rsel),
        .rd1 (rs1_val),
        .rd2 (rs2_val),
        .rd3 (dbg_rdata),
        .we  (rf_we),
        .wa  (instr[7 +: RAW]),
        .wd  (wb_data)
    );

    assign alu_b = ctrl.b_from_imm ? imm : rs2_val;

    rvmini_alu #(.XLEN(XLEN)) u_alu (
        .op   (alu_op),
        .a    (rs1_val),
        .b    (alu_b),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // Memory stage (word addressed)
    assign dm_idx   = alu_y[DAW+1:2];
    assign dm_rdata = dmem[dm_idx];
    assign dm_we    = ctrl.mem_write;

    always @(posedge clk) begin
        if (dm_we) begin
            dmem[dm_idx] <= rs2_val;
        end
    end

    // Write-back
    assign rf_we   = ctrl.reg_write;
    assign wb_data = ctrl.mem_read ? dm_rdata : alu_y;

    // Next PC: sequential or branch-redirect
    assign pc_seq   = pc_q + STEP;
    assign pc_tgt   = pc_q + imm;
    assign redirect = ctrl.branch & alu_zero;
    assign pc_d     = redirect ? pc_tgt : pc_seq;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_d;
        end
    end

    assign dbg_pc = pc_q;

endmodule

// File: rtl/rvmini_core_chk.sv
module rvmini_core_chk
    import rvmini_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int RAW  = 5
) (
    input logic            clk,
    input logic            rst,
    input logic [XLEN-1:0] pc,
    input logic [31:0]     instr,
    input logic [XLEN-1:0] rs1_val,
    input logic [XLEN-1:0] rs2_val,
    input logic            rf_we,
    input logic            dm_we,
    input logic [XLEN-1:0] wb_data,
    input logic [XLEN-1:0] dm_rdata,
    input logic [RAW-1:0]  dbg_rsel,
    input logic [XLEN-1:0] dbg_rdata
);

    localparam logic [XLEN-1:0] FOUR = XLEN'(4);

    logic [XLEN-1:0] b_off;
    logic            is_beq;
    logic            known_op;
    logic            rst_seen_q;

    assign b_off  = {{(XLEN-12){instr[31]}}, instr[7], instr[30:25], instr[11:8], 1'b0};
    assign is_beq = (instr[6:0] == OPC_BRANCH);
    assign known_op = (instr[6:0] == OPC_REG) || (instr[6:0] == OPC_LOAD) ||
                      (instr[6:0] == OPC_STORE) || is_beq;

    always_ff @(posedge clk) begin
        rst_seen_q <= rst;
    end

    // R1
    always_ff @(posedge clk) begin
        if (rst_seen_q) begin
            pc_reset_chk: assert (pc == '0)
                else $error("pc not zero after reset");
        end
    end

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        !(is_beq && (rs1_val == rs2_val)) |=> (pc == $past(pc) + FOUR));

    // R3
    branch_target_chk: assert property (@(posedge clk) disable iff (rst)
        (is_beq && (rs1_val == rs2_val)) |=> (pc == $past(pc) + $past(b_off)));

    // R5
    zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
        (dbg_rsel == '0) |-> (dbg_rdata == '0));

    // R6
    load_wb_chk: assert property (@(posedge clk) disable iff (rst)
        (instr[6:0] == OPC_LOAD) |-> (rf_we && (wb_data == dm_rdata)));

    // R7
    store_nowb_chk: assert property (@(posedge clk) disable iff (rst)
        (instr[6:0] == OPC_STORE) |-> (dm_we && !rf_we));

    // R8
    inert_op_chk: assert property (@(posedge clk) disable iff (rst)
        !known_op |-> (!rf_we && !dm_we));

endmodule

bind rvmini_core rvmini_core_chk #(.XLEN(XLEN), .RAW(RAW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pc        (pc_q),
    .instr     (instr),
    .rs1_val   (rs1_val),
    .rs2_val   (rs2_val),
    .rf_we     (rf_we),
    .dm_we     (dm_we),
    .wb_data   (wb_data),
    .dm_rdata  (dm_rdata),
    .dbg_rsel  (dbg_rsel),
    .dbg_rdata (dbg_rdata)
);

// File: tb/rvmini_core_bench.sv
module rvmini_core_bench;

    localparam int CLK_PERIOD = 10;
    localparam int RUN_CYCLES = 80;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  dbg_rsel = '0;
    logic [31:0] dbg_pc;
    logic [31:0] dbg_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Behavioural machine state
    logic [31:0] m_pc;
    logic [31:0] m_reg  [32];
    logic [31:0] m_mem  [64];
    logic [31:0] m_imem [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    rvmini_core u_rvmini_core (
        .clk       (clk),
        .rst       (rst),
        .dbg_pc    (dbg_pc),
        .dbg_rsel  (dbg_rsel),
        .dbg_rdata (dbg_rdata)
    );

    function automatic logic [31:0] enc_r(input logic [6:0] f7, input int rs2,
                                          input int rs1, input logic [2:0] f3, input int rd);
        return {f7, rs2[4:0], rs1[4:0], f3, rd[4:0], 7'b0110011};
    endfunction

    function automatic logic [31:0] enc_lw(input int rd, input int rs1, input int off);
        logic [11:0] o = off[11:0];
        return {o, rs1[4:0], 3'b010, rd[4:0], 7'b0000011};
    endfunction

    function automatic logic [31:0] enc_sw(input int rs2, input int rs1, input int off);
        logic [11:0] o = off[11:0];
        return {o[11:5], rs2[4:0], rs1[4:0], 3'b010, o[4:0], 7'b0100011};
    endfunction

    function automatic logic [31:0] enc_beq(input int rs1, input int rs2, input int off);
        logic [12:0] o = off[12:0];
        return {o[12], o[10:5], rs2[4:0], rs1[4:0], 3'b000, o[4:1], o[11], 7'b1100011};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_pc = '0;
        for (int i = 0; i < 32; i++) m_reg[i] = '0;
    endtask

    // One instruction of the architectural model
    task automatic model_step();
        logic [31:0] ins, a, b, res, addr, nxt;
        logic [4:0]  rd;
        ins = m_imem[m_pc[7:2]];
        rd  = ins[11:7];
        a   = m_reg[ins[19:15]];
        b   = m_reg[ins[24:20]];
        nxt = m_pc + 32'd4;
        case (ins[6:0])
            7'b0110011: begin
                if (ins[14:12] == 3'b111)      res = a & b;
                else if (ins[14:12] == 3'b110) res = a | b;
                else if (ins[31:25] == 7'b0100000) res = a - b;
                else res = a + b;
                if (rd != 0) m_reg[rd] = res;
            end
            7'b0000011: begin
                addr = a + {{20{ins[31]}}, ins[31:20]};
                if (rd != 0) m_reg[rd] = m_mem[addr[7:2]];
            end
            7'b0100011: begin
                addr = a + {{20{ins[31]}}, ins[31:25], ins[11:7]};
                m_mem[addr[7:2]] = b;
            end
            7'b1100011: begin
                if (a == b)
                    nxt = m_pc + {{19{ins[31]}}, ins[31], ins[7], ins[30:25], ins[11:8], 1'b0};
            end
            default: ;
        endcase
        m_pc = nxt;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        logic [31:0] prog [20];
        #1;
        prog[0]  = enc_lw(1, 0, 0);
        prog[1]  = enc_lw(2, 0, 4);
        prog[2]  = enc_r(7'b0000000, 1, 3, 3'b000, 3);   // add x3,x3,x1
        prog[3]  = enc_r(7'b0000000, 3, 4, 3'b000, 4);   // add x4,x4,x3
        prog[4]  = enc_beq(3, 2, 8);
        prog[5]  = enc_beq(0, 0, -12);
        prog[6]  = enc_sw(4, 0, 8);
        prog[7]  = enc_lw(5, 0, 8);
        prog[8]  = enc_r(7'b0100000, 2, 5, 3'b000, 6);   // sub x6,x5,x2
        prog[9]  = enc_r(7'b0000000, 2, 5, 3'b111, 7);   // and x7,x5,x2
        prog[10] = enc_r(7'b0000000, 1, 6, 3'b110, 8);   // or  x8,x6,x1
        prog[11] = enc_r(7'b0000000, 5, 5, 3'b000, 0);   // add x0,x5,x5
        prog[12] = {12'd5, 5'd0, 3'd0, 5'd13, 7'b0010011}; // unsupported opcode
        prog[13] = enc_lw(9, 0, 12);
        prog[14] = enc_sw(8, 9, -4);
        prog[15] = enc_lw(10, 0, 28);
        prog[16] = enc_r(7'b0100000, 2, 1, 3'b000, 11); // sub x11,x1,x2
        prog[17] = enc_beq(11, 1, 8);
        prog[18] = enc_r(7'b0000000, 0, 11, 3'b110, 12); // or x12,x11,x0
        prog[19] = enc_beq(0, 0, 0);
        for (int i = 0; i < 64; i++) begin
            m_imem[i] = (i < 20) ? prog[i] : 32'h0;
            u_rvmini_core.imem[i] = m_imem[i];
            m_mem[i] = '0;
        end
        m_mem[0] = 32'd1;
        m_mem[1] = 32'd5;
        m_mem[3] = 32'd32;
        for (int i = 0; i < 64; i++) u_rvmini_core.dmem[i] = m_mem[i];
        model_reset();

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "pc in reset", dbg_pc, 32'h0);
        for (int i = 0; i < 32; i++) begin
            dbg_rsel = 5'(i);
            #1;
            check("R1", $sformatf("x%0d in reset", i), dbg_rdata, 32'h0);
        end
        @(negedge clk);
        rst = 1'b0;

        for (int c = 0; c < RUN_CYCLES; c++) begin
            logic [31:0] ins;
            string       rtag;
            string       ptag;
            ins = m_imem[m_pc[7:2]];
            case (ins[6:0])
                7'b0110011: rtag = "R4";
                7'b0000011: rtag = "R6";
                7'b0100011: rtag = "R7";
                7'b1100011: rtag = "R3";
                default:    rtag = "R8";
            endcase
            if (ins[11:7] == 5'd0) rtag = "R5";
            ptag = (ins[6:0] == 7'b1100011) ? "R3" : (rtag == "R8" ? "R8" : "R2");
            dbg_rsel = ins[11:7];
            model_step();
            @(negedge clk);
            check(ptag, $sformatf("pc cycle %0d", c), dbg_pc, m_pc);
            check(rtag, $sformatf("x%0d cycle %0d", dbg_rsel, c), dbg_rdata, m_reg[dbg_rsel]);
        end

        // Final architectural values from the program's intent
        check("R3", "halt pc", dbg_pc, 32'h0000_004C);
        begin
            logic [31:0] expv [32];
            for (int i = 0; i < 32; i++) expv[i] = '0;
            expv[1] = 32'd1;  expv[2] = 32'd5;  expv[3] = 32'd5;  expv[4] = 32'd15;
            expv[5] = 32'd15; expv[6] = 32'd10; expv[7] = 32'd5;  expv[8] = 32'd11;
            expv[9] = 32'd32; expv[10] = 32'd11;
            expv[11] = 32'hFFFF_FFFC; expv[12] = 32'hFFFF_FFFC;
            for (int i = 0; i < 32; i++) begin
                dbg_rsel = 5'(i);
                #1;
                check((i == 0) ? "R5" : "R9", $sformatf("final x%0d", i), dbg_rdata, expv[i]);
            end
        end

        // R1: reset applied in mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1", "pc after late reset", dbg_pc, 32'h0);
        for (int i = 0; i < 32; i++) begin
            dbg_rsel = 5'(i);
            #1;
            check("R1", $sformatf("x%0d after late reset", i), dbg_rdata, 32'h0);
        end
        rst = 1'b0;

        done = 1'b1;
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            finish_run();
        end
    end

endmodule